// File: doc/BRIEF.md
# Daisy-Chain Bus Arbitration Unit

This block is the arbitration front end that each master carries on a shared parallel system bus. It runs on the bus clock, accepts a request level from its local master and decides when that master may take the bus. It drives the active-low request, busy, common-request and priority-out lines, and it hands the local master a grant level that stays high for as long as this unit holds the bus. In a serial arrangement, units are chained through priority-out and priority-in, with the head of the chain at the highest priority. In a parallel arrangement, priority-in comes from an external resolver that watches the request lines of all masters.

The behaviour is a three-state machine. In `ST_IDLE` the unit drives nothing and passes priority straight down the chain. The transition *REQUEST* (IDLE to WAIT) happens on the first edge that sees the local request. In `ST_WAIT` the unit asserts bus-request and common-request and blocks lower masters. *ACQUIRE* (WAIT to OWN) happens on an edge where the request is still present, priority-in is asserted and the shared busy line is free. *WITHDRAW* (WAIT to IDLE) happens when the request drops before ownership. In `ST_OWN` the unit asserts busy and releases common-request. *RELEASE* (OWN to IDLE) follows the drop of the local request. *YIELD* (OWN to WAIT) gives up the bus when yielding is permitted, another master signals common-request and priority-in shows that a higher master is waiting.

The busy and common-request lines are shared open-drain wires, so each is split into a drive output and a sampled input. A system ANDs the drive outputs of all units, because the lines are active low, and returns the result to every unit's input.

Top module: `bus_arb_unit`

## Requirements
- R1: While rst_n is low the unit is in ST_IDLE, whatever loc_req is: grant is 0, breq_n_o, busy_n_o and creq_n_o are 1, and pri_out_n equals pri_in_n.
- R2: From ST_IDLE, the first rising clk edge with loc_req high drives breq_n_o and creq_n_o low and leaves grant at 0 (REQUEST).
- R3: A waiting unit takes the bus on a clk edge where loc_req is 1, pri_in_n is 0 and busy_n_i is 1. From that edge onward grant is 1, busy_n_o is 0 and creq_n_o is 1 (ACQUIRE).
- R4: A waiting unit does not take the bus on an edge where busy_n_i is 0 or pri_in_n is 1. It keeps creq_n_o low.
- R5: An owner whose loc_req stays high keeps grant for every following cycle unless R7 applies.
- R6: When loc_req is low at an edge while the unit owns the bus, that edge clears grant and sets busy_n_o and breq_n_o to 1 (RELEASE).
- R7: An owner with loc_req high, yield_n 0, creq_n_i 0 and pri_in_n 1 gives up the bus on that edge. It returns to waiting with grant 0, busy_n_o 1 and creq_n_o 0 (YIELD).
- R8: With yield_n high, an owner ignores creq_n_i and keeps the bus.
- R9: With SERIAL_CHAIN=1, pri_out_n is 1 whenever breq_n_o is 0, and it equals pri_in_n while the unit is idle.
- R10: In a chain, of the units requesting together from idle, the one nearest the head gains the bus two edges after the request. No two units ever hold grant at once. When the owner releases, the next-highest waiting unit takes the bus two edges after its release input.
- R11: A waiting unit whose loc_req drops returns to ST_IDLE at the next edge, with breq_n_o and creq_n_o back at 1 (WITHDRAW).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loc_req | input | 1 | Local master needs the bus (active high) |
| yield_n | input | 1 | Low: the owner may yield to a waiting higher master |
| pri_in_n | input | 1 | Low: no higher-priority master is requesting |
| busy_n_i | input | 1 | Sampled shared busy line (low = bus in use) |
| creq_n_i | input | 1 | Sampled shared common-request line |
| grant | output | 1 | Local master owns the bus |
| breq_n_o | output | 1 | Bus-request drive, low while waiting or owning |
| busy_n_o | output | 1 | Busy drive, low while owning |
| creq_n_o | output | 1 | Common-request drive, low while waiting |
| pri_out_n | output | 1 | Priority to the next lower master in the chain |

## Verification
The bound checker watches one unit on every cycle. It checks that ownership only begins after an edge that met the acquire conditions, that release and yield act on the next edge, that an owner keeps the bus when neither release nor yield applies, that a withdrawn request clears the request lines, and that a requesting unit always blocks the chain. The bench covers what only the whole system can show. It uses three chained units with wired busy and common-request lines. It sweeps every request pattern to check who wins, that at most one unit owns the bus at a time, and that the bus is handed to the next waiting unit. It also covers yield across the chain and the effect of reset with requests held.

// File: rtl/arb_pkg.sv
package arb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_OWN  = 2'd2
    } arb_state_t;
endpackage

// File: rtl/arb_fsm.sv
module arb_fsm
    import arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       loc_req,
    input  logic       yield_n,
    input  logic       pri_in_n,
    input  logic       busy_n_i,
    input  logic       creq_n_i,
    output arb_state_t state
);
    arb_state_t state_nx;
    logic       can_take;
    logic       must_yield;

    // Bus is free for us: priority granted, nobody holds busy.
    assign can_take   = loc_req && !pri_in_n && busy_n_i;
    // A higher master is waiting and yielding is permitted.
    assign must_yield = !yield_n && !creq_n_i && pri_in_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (loc_req) state_nx = ST_WAIT;                // REQUEST
            ST_WAIT: begin
                if (!loc_req)      state_nx = ST_IDLE;               // WITHDRAW
                else if (can_take) state_nx = ST_OWN;                // ACQUIRE
            end
            ST_OWN: begin
                if (!loc_req)        state_nx = ST_IDLE;             // RELEASE
                else if (must_yield) state_nx = ST_WAIT;             // YIELD
            end
            default: state_nx = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/arb_drive.sv
module arb_drive
    import arb_pkg::*;
#(
    parameter bit SERIAL_CHAIN = 1'b1
) (
    input  arb_state_t state,
    input  logic       pri_in_n,
    output logic       grant,
    output logic       breq_n_o,
    output logic       busy_n_o,
    output logic       creq_n_o,
    output logic       pri_out_n
);
    logic active;

    always_comb begin
        grant    = 1'b0;
        active   = 1'b0;
        busy_n_o = 1'b1;
        creq_n_o = 1'b1;
        unique case (state)
            ST_IDLE: ;
            ST_WAIT: begin
                active   = 1'b1;
                creq_n_o = 1'b0;
            end
            ST_OWN: begin
                active   = 1'b1;
                grant    = 1'b1;
                busy_n_o = 1'b0;
            end
            default: ;
        endcase
        breq_n_o = !active;
    end

    generate
        if (SERIAL_CHAIN) begin : g_serial
            assign pri_out_n = active ? 1'b1 : pri_in_n;
        end else begin : g_parallel
            assign pri_out_n = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/bus_arb_unit.sv
module bus_arb_unit
    import arb_pkg::*;
#(
    parameter bit SERIAL_CHAIN = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic loc_req,
    input  logic yield_n,
    input  logic pri_in_n,
    input  logic busy_n_i,
    input  logic creq_n_i,
    output logic grant,
    output logic breq_n_o,
    output logic busy_n_o,
    output logic creq_n_o,
    output logic pri_out_n
);
    arb_state_t state;

    arb_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .loc_req  (loc_req),
        .yield_n  (yield_n),
        .pri_in_n (pri_in_n),
        .busy_n_i (busy_n_i),
        .creq_n_i (creq_n_i),
        .state    (state)
    );

    arb_drive #(.SERIAL_CHAIN(SERIAL_CHAIN)) u_drive (
        .state     (state),
        .pri_in_n  (pri_in_n),
        .grant     (grant),
        .breq_n_o  (breq_n_o),
        .busy_n_o  (busy_n_o),
        .creq_n_o  (creq_n_o),
        .pri_out_n (pri_out_n)
    );
endmodule

// File: rtl/bus_arb_unit_chk.sv
module bus_arb_unit_chk (
    input logic clk,
    input logic rst_n,
    input logic loc_req,
    input logic yield_n,
    input logic pri_in_n,
    input logic busy_n_i,
    input logic creq_n_i,
    input logic grant,
    input logic breq_n_o,
    input logic busy_n_o,
    input logic creq_n_o,
    input logic pri_out_n
);
    // R2
    request_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (breq_n_o && loc_req) |=> (!breq_n_o && !creq_n_o && !grant));

    // R3
    acquire_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant) |-> ($past(loc_req && !pri_in_n && busy_n_i) && creq_n_o && !busy_n_o));

    // R4
    wait_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!creq_n_o && (!busy_n_i || pri_in_n)) |=> !grant);

    // R5
    hold_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && loc_req && (yield_n || creq_n_i || !pri_in_n)) |=> grant);

    // R6
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && !loc_req) |=> (!grant && busy_n_o && breq_n_o));

    // R7
    yield_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && loc_req && !yield_n && !creq_n_i && pri_in_n) |=> (!grant && busy_n_o && !creq_n_o));

    // R9
    chain_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !breq_n_o |-> pri_out_n);

    // R11
    withdraw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!creq_n_o && !loc_req) |=> (breq_n_o && creq_n_o));
endmodule

bind bus_arb_unit bus_arb_unit_chk u_chk (.*);

// File: tb/tb_bus_arb_unit.sv
module tb_bus_arb_unit;
    localparam int N = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req = '0;
    logic [N-1:0] yld_n = '1;
    logic [N-1:0] grant, breq_n, busy_n, creq_n, pout_n, pin_n;
    logic         busy_bus, creq_bus;
    int           n_chk = 0;
    int           n_fail = 0;
    bit           done = 1'b0;

    always #5 clk = ~clk;

    assign pin_n    = {pout_n[N-2:0], 1'b0};
    assign busy_bus = &busy_n;
    assign creq_bus = &creq_n;

    for (genvar i = 0; i < N; i++) begin : gen_u
        bus_arb_unit dut (
            .clk(clk), .rst_n(rst_n), .loc_req(req[i]), .yield_n(yld_n[i]),
            .pri_in_n(pin_n[i]), .busy_n_i(busy_bus), .creq_n_i(creq_bus),
            .grant(grant[i]), .breq_n_o(breq_n[i]), .busy_n_o(busy_n[i]),
            .creq_n_o(creq_n[i]), .pri_out_n(pout_n[i])
        );
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    function automatic logic [N-1:0] first_set(input logic [N-1:0] p);
        return p & (~p + 1'b1);
    endfunction

    // Serial chain: a requesting unit drives 1, an idle one passes its input.
    function automatic logic [N-1:0] chain_out(input logic [N-1:0] act);
        logic [N-1:0] o;
        logic         prev;
        prev = 1'b0;
        for (int i = 0; i < N; i++) begin
            o[i] = act[i] ? 1'b1 : prev;
            prev = o[i];
        end
        return o;
    endfunction

    initial begin
        logic [N-1:0] w, rest;
        // R1: requests held high during reset have no effect
        req = '1;
        tick(3);
        check("R1 grant", grant, '0);
        check("R1 breq_n", breq_n, '1);
        check("R1 busy_n", busy_n, '1);
        check("R1 creq_n", creq_n, '1);
        check("R1 pri_out_n", pout_n, '0);
        req = '0;
        tick(1);
        rst_n = 1'b1;
        tick(1);
        check("R1 idle after reset", grant, '0);

        // R10 sweep over every request pattern
        for (int p = 1; p < (1 << N); p++) begin
            req = p[N-1:0];
            tick(1);
            check("R2 breq_n", breq_n, ~p[N-1:0]);
            check("R2 creq_n", creq_n, ~p[N-1:0]);
            check("R2 no grant yet", grant, '0);
            check("R9 chain blocked", pout_n, chain_out(p[N-1:0]));
            tick(1);
            w = first_set(p[N-1:0]);
            rest = p[N-1:0] & ~w;
            check("R10 winner", grant, w);
            check("R3 busy_n", busy_n, ~w);
            check("R4 losers keep creq", creq_n, ~rest);
            req = rest;
            tick(1);
            check("R6 release grant", grant, '0);
            check("R6 release breq_n", breq_n, ~rest);
            tick(1);
            check("R10 handoff", grant, first_set(rest));
            req = '0;
            tick(2);
            check("R6 all idle", breq_n, '1);
            check("R9 idle passes priority", pout_n, '0);
        end

        // R5: owner keeps the bus while requesting
        req = 3'b010;
        tick(2);
        check("R5 acquire", grant, 3'b010);
        tick(6);
        check("R5 hold", grant, 3'b010);
        req = '0;
        tick(2);

        // R8: lowest owns, head waits, yield disabled
        req = 3'b100;
        tick(2);
        req = 3'b101;
        tick(3);
        check("R8 owner ignores creq", grant, 3'b100);
        check("R4 blocked waiter", creq_n, 3'b110);
        // R7: enable yield on the owner
        yld_n = 3'b011;
        tick(1);
        check("R7 yield grant", grant, 3'b000);
        check("R7 yield creq_n", creq_n, 3'b010);
        tick(1);
        check("R7 head takes bus", grant, 3'b001);
        req = '0;
        yld_n = '1;
        tick(2);

        // R11: waiter withdraws while head owns
        req = 3'b011;
        tick(2);
        check("R11 setup", grant, 3'b001);
        req = 3'b001;
        tick(1);
        check("R11 breq_n", breq_n, 3'b110);
        check("R11 creq_n", creq_n, 3'b111);
        check("R11 owner kept", grant, 3'b001);
        req = '0;
        tick(2);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule